// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-on to its ready state. After reset it keeps clock-enable low and the chip select deasserted. It then waits for a start pulse. On that pulse it counts a 200 µs settling delay, derived from the clock frequency parameter. Next it raises clock-enable with a single NOP and issues the fixed command order that the device needs:

1. a precharge of all banks;
2. an extended mode write that turns the delay-locked loop on;
3. a mode write that resets the delay-locked loop and sets the operating parameters;
4. a second precharge of all banks;
5. two auto refreshes;
6. a last mode write with the same parameters and the loop-reset bit cleared.

Each command is followed by its minimum spacing, filled with deselect cycles. The ready flag does not rise until the loop-lock window has passed since the loop-reset write. After that, the controller's normal traffic takes over the command pins.

The mode and extended-mode values, the loop-reset bit position and all timings (tRP, tMRD, tRFC, the lock window) are parameters counted in clock cycles.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start pulse arrives, cke is 0, cs_n is 1, busy is 0 and done is 0.
- R2: After start is sampled, busy is 1 and at least WAIT_US*CLK_MHZ cycles pass with cke 0 and cs_n 1 before the first command.
- R3: The first command is a NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), issued in the same cycle that cke first goes to 1. From then on cke stays 1.
- R4: A precharge-all command (4'b0010, addr = 13'h400, meaning only A10 set, ba = 0) is issued right after the NOP and again right after the loop-reset mode write.
- R5: The third command is a mode write (4'b0000) with ba = 2'b01 and addr = EMR_VAL.
- R6: The fourth command is a mode write with ba = 2'b00 and addr = MR_VAL with bit DLL_RST_BIT set.
- R7: Two auto-refresh commands (4'b0001, ba = 0, addr = 0) follow the second precharge.
- R8: The eighth and last command is a mode write with ba = 2'b00 and addr = MR_VAL with bit DLL_RST_BIT cleared. done rises at least T_MRD cycles after it.
- R9: The spacing between successive commands is at least 1 after the NOP, T_RP after each precharge, T_MRD after each mode write, and T_RFC after each refresh.
- R10: done rises no earlier than DLL_LOCK cycles after the loop-reset mode write. busy and done are never 1 together.
- R11: cs_n is 0 in exactly eight cycles of a sequence, the eight commands above, and in no other cycle.
- R12: A start pulse while busy or done has no effect: the command stream is unchanged, and done stays 1 with no new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when the block is idle |
| cke | output | 1 | Clock enable toward the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Address / mode op-code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Device initialized and ready |

## Verification
The bench records every cycle in which cs_n is low, together with a cycle stamp. A table of the eight expected commands (code, bank, address, minimum spacing) is then walked against that record, which separates errors in order, in encoding, in mode-value contents and in spacing. A clean start is followed by extra start pulses during the settling wait and after done, which separates a correctly ignored start from one that restarts or lengthens the run. A reset during the wait shows that the block returns to its idle outputs. The rise of done is timed against both the loop-reset write and the last mode write, which separates a lock window that is honoured from one that is merely covered by the command gaps.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int          CLK_MHZ     = 250,
  parameter int          WAIT_US     = 200,
  parameter int          T_RP        = 4,
  parameter int          T_MRD       = 2,
  parameter int          T_RFC       = 18,
  parameter int          DLL_LOCK    = 200,
  parameter int          DLL_RST_BIT = 8,
  parameter logic [12:0] MR_VAL      = 13'h022,
  parameter logic [12:0] EMR_VAL     = 13'h000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr,
  output logic        busy,
  output logic        done
);
  localparam int WAIT_CYC = WAIT_US * CLK_MHZ;
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam int LW = $clog2(DLL_LOCK + 1);
  localparam logic [12:0] RST_MASK = 13'(1) << DLL_RST_BIT;
  localparam logic [2:0] LAST_STEP = 3'd7;
  localparam logic [2:0] RST_STEP  = 3'd3;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_CMD, S_GAP, S_FIN, S_DONE} st_t;

  st_t          st;
  logic [2:0]   step;
  logic [CW-1:0] cnt;
  logic [LW-1:0] lock_cnt;

  logic [3:0]   c_code;
  logic [1:0]   c_ba;
  logic [12:0]  c_a;
  logic [CW-1:0] c_gap;

  always_comb begin
    c_code = 4'b0111; c_ba = 2'b00; c_a = '0; c_gap = CW'(1);
    case (step)
      3'd0: begin c_code = 4'b0111; c_gap = CW'(1); end
      3'd1, 3'd4: begin c_code = 4'b0010; c_a = 13'h400; c_gap = CW'(T_RP); end
      3'd2: begin c_code = 4'b0000; c_ba = 2'b01; c_a = EMR_VAL; c_gap = CW'(T_MRD); end
      3'd3: begin c_code = 4'b0000; c_a = MR_VAL | RST_MASK; c_gap = CW'(T_MRD); end
      3'd5, 3'd6: begin c_code = 4'b0001; c_gap = CW'(T_RFC); end
      default: begin c_code = 4'b0000; c_a = MR_VAL & ~RST_MASK; c_gap = CW'(T_MRD); end
    endcase
  end

  wire issuing = (st == S_CMD);

  assign cke  = (st != S_IDLE) && (st != S_WAIT);
  assign {cs_n, ras_n, cas_n, we_n} = issuing ? c_code : 4'b1111;
  assign ba   = issuing ? c_ba : 2'b00;
  assign addr = issuing ? c_a : 13'h0;
  assign busy = (st == S_WAIT) || (st == S_CMD) || (st == S_GAP) || (st == S_FIN);
  assign done = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin st <= S_WAIT; cnt <= CW'(WAIT_CYC - 1); end
        S_WAIT: if (cnt == '0) begin st <= S_CMD; step <= '0; end
                else cnt <= cnt - 1'b1;
        S_CMD: begin
          if (c_gap > CW'(1)) begin
            st <= S_GAP; cnt <= c_gap - CW'(2);
          end else if (step == LAST_STEP) st <= S_FIN;
          else step <= step + 1'b1;
        end
        S_GAP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (step == LAST_STEP) st <= S_FIN;
          else begin st <= S_CMD; step <= step + 1'b1; end
        end
        S_FIN: if (lock_cnt == '0) st <= S_DONE;
        default: st <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_cnt <= '0;
    else if (issuing && step == RST_STEP) lock_cnt <= LW'(DLL_LOCK - 1);
    else if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
  end

  // R3
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke);
  // R3
  cke_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));
  // R10
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  // R10
  done_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (lock_cnt == '0));
  // R11
  cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (ras_n == 1'b0 || (cas_n && we_n)) && cke);
  // R12
  done_stay_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> done);
  // R2
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cke) |-> cs_n);
endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;
  localparam int WAIT_CYC = 200 * 250;
  localparam int T_RP = 4, T_MRD = 2, T_RFC = 18, DLL_LOCK = 200;
  localparam logic [12:0] MR = 13'h022;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, busy, done;
  logic [1:0] ba;
  logic [12:0] addr;

  ddr_init_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .busy(busy), .done(done));

  always #2 clk = ~clk;

  // {code, ba, addr, min spacing from previous command}
  localparam logic [34:0] EXP [8] = '{
    {4'b0111, 2'b00, 13'h000, 16'd0},
    {4'b0010, 2'b00, 13'h400, 16'd1},
    {4'b0000, 2'b01, 13'h000, 16'(T_RP)},
    {4'b0000, 2'b00, MR | 13'h100, 16'(T_MRD)},
    {4'b0010, 2'b00, 13'h400, 16'(T_MRD)},
    {4'b0001, 2'b00, 13'h000, 16'(T_RP)},
    {4'b0001, 2'b00, 13'h000, 16'(T_RFC)},
    {4'b0000, 2'b00, MR, 16'(T_RFC)}};

  int cyc = 0, checks = 0, failures = 0, n_cmd = 0;
  int t0 = -1, t_done = -1;
  bit cap_en = 0, cke_early = 0, cke_drop = 0, seen_cke = 0, both = 0;
  logic [3:0] r_code [16];
  logic [1:0] r_ba [16];
  logic [12:0] r_a [16];
  bit r_cke [16];
  int r_t [16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && cap_en) begin
    if (busy && t0 < 0) t0 = cyc;
    if (busy && done) both = 1;
    if (busy && cke && n_cmd == 0 && cs_n) cke_early = 1;
    if (seen_cke && !cke) cke_drop = 1;
    if (cke) seen_cke = 1;
    if (done && t_done < 0) t_done = cyc;
    if (!cs_n && n_cmd < 16) begin
      r_code[n_cmd] = {cs_n, ras_n, cas_n, we_n}; r_ba[n_cmd] = ba; r_a[n_cmd] = addr;
      r_cke[n_cmd] = cke; r_t[n_cmd] = cyc; n_cmd++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic idle_chk(input string req);
    chk(cke == 1'b0, req, cke, 0);
    chk(cs_n == 1'b1, req, cs_n, 1);
    chk(busy == 1'b0 && done == 1'b0, req, {busy, done}, 0);
  endtask

  bit finished = 0;
  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    idle_chk("R1 after reset");
    cap_en = 1;
    pulse_start();
    repeat (100) @(negedge clk);
    chk(busy == 1'b1, "R2 busy", busy, 1);
    pulse_start();  // R12 start while busy
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    pulse_start();  // R12 start after done
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R12 done holds", done, 1);
    chk(n_cmd == 8, "R11 command count", n_cmd, 8);
    if (n_cmd >= 8) begin
      for (int i = 0; i < 8; i++) begin
        chk(r_code[i] == EXP[i][34:31], "R4/R5/R6/R7 command code", r_code[i], EXP[i][34:31]);
        chk(r_ba[i] == EXP[i][30:29], "R5/R6 bank", r_ba[i], EXP[i][30:29]);
        chk(r_a[i] == EXP[i][28:16], "R4/R6/R8 address", r_a[i], EXP[i][28:16]);
        if (i > 0)
          chk(r_t[i] - r_t[i-1] >= int'(EXP[i][15:0]), "R9 spacing",
              r_t[i] - r_t[i-1], EXP[i][15:0]);
      end
      chk(r_t[0] - t0 >= WAIT_CYC, "R2 wait length", r_t[0] - t0, WAIT_CYC);
      chk(r_cke[0] == 1'b1, "R3 cke with NOP", r_cke[0], 1);
      chk(t_done - r_t[3] >= DLL_LOCK, "R10 lock window", t_done - r_t[3], DLL_LOCK);
      chk(t_done - r_t[7] >= T_MRD, "R8 final spacing", t_done - r_t[7], T_MRD);
    end
    chk(!cke_early, "R2 cke low in wait", cke_early, 0);
    chk(!cke_drop, "R3 cke stays high", cke_drop, 0);
    chk(!both, "R10 busy and done", both, 0);
    cap_en = 0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    pulse_start();
    repeat (300) @(negedge clk);
    chk(busy == 1'b1 && cke == 1'b0, "R2 second run waiting", {busy, cke}, 2);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    idle_chk("R1 reset mid-wait");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule